// File: doc/BRIEF.md
# Three-Wire Serial Clock-Chip Master

This block lets on-chip logic read and write single registers of an external real-time-clock device. The device is reached over three wires: an active-high chip enable, a serial clock generated by this block, and one shared data wire. The shared wire is modelled as separate output, output-enable and input signals, which a pad cell combines.

A client presents a 6-bit register index, a read flag and a write byte on a valid/ready handshake. The block frames the transfer with chip enable and sends a command byte. It then either sends the data byte or releases the data wire and collects eight bits returned by the device. The end of every transfer is marked by a one-cycle done pulse. For a read, the returned byte is on `rd_byte` from that pulse onward.

Each half period of the serial clock lasts `HALF_CYC` system clocks. In the device's read protocol, each read bit is launched on a falling clock edge. The first read bit is therefore already on the wire when the command byte ends, and seven more clock pulses complete the byte.

Top module: `rtc3w_master`

## Requirements
- R1: The serial clock is low whenever chip enable is low. Chip enable rises while the serial clock is low, before the first rising edge of a transfer, and stays high through the command and data phases.
- R2: The command byte has bit 7 = 1, bits 6..1 = register index, and bit 0 = 1 for a read or 0 for a write. It is sent least-significant bit first, and the data output changes only while the serial clock is low.
- R3: The serial clock stays high for exactly `HALF_CYC` system clocks on every pulse.
- R4: A write transfer makes exactly 16 rising serial-clock edges: 8 command bits followed by the 8 data bits, least-significant bit first.
- R5: On a read, the output enable drops on the same cycle as the falling edge that ends the eighth command bit. The output is then not driven again until the next transfer begins, so the block never drives the wire while the device may be driving it.
- R6: A read transfer makes exactly 15 rising edges. The first read bit is sampled before any further pulse. `rd_byte` holds the eight sampled bits, with the first sampled bit in bit 0.
- R7: Every transfer ends with chip enable falling while the serial clock is low. `done` is high for exactly that one cycle, and `rd_byte` is valid from then on after a read.
- R8: Between the fall of chip enable and its next rise there are at least 2×`HALF_CYC` system clocks.
- R9: `req_ready` is the inverse of `busy`. `busy` rises on the cycle after a request is accepted and stays high through the transfer and the recovery gap. A request offered while busy is not executed.
- R10: After reset, chip enable, serial clock, output enable and done are low, and the block is ready.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Request accepted when high together with req_valid |
| req_read | input | 1 | 1 = read, 0 = write |
| req_index | input | 6 | Register index |
| req_wbyte | input | 8 | Byte to write |
| busy | output | 1 | Transfer or recovery gap in progress |
| done | output | 1 | One-cycle pulse at the end of a transfer |
| rd_byte | output | 8 | Byte captured by the last read |
| ser_ce | output | 1 | Chip enable to the device |
| ser_clk | output | 1 | Serial clock to the device |
| ser_dout | output | 1 | Data toward the device |
| ser_doe | output | 1 | Output enable for the data pad |
| ser_din | input | 1 | Data from the device |

## Verification
The assertions assume that `ser_din` comes from a device that drives only after a falling serial-clock edge of a read, and that the client holds a request stable until it is accepted. The bench meets both conditions with a behavioural device model. The model shifts on rising edges and launches read bits on falling edges only after a complete read command. The bench driver raises `req_valid` only at a falling system-clock edge while `req_ready` is high. The only exception is a deliberate pulse issued while the block is busy. Its absence is confirmed by the absence of an extra frame and by reading the targeted register back.

// File: rtl/rtc3w_master.sv
module rtc3w_master #(
  parameter int HALF_CYC = 4
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       req_valid,
  output logic       req_ready,
  input  logic       req_read,
  input  logic [5:0] req_index,
  input  logic [7:0] req_wbyte,
  output logic       busy,
  output logic       done,
  output logic [7:0] rd_byte,
  output logic       ser_ce,
  output logic       ser_clk,
  output logic       ser_dout,
  output logic       ser_doe,
  input  logic       ser_din
);

  localparam int DW = (HALF_CYC > 1) ? $clog2(HALF_CYC) : 1;
  localparam logic [DW-1:0] DLAST = DW'(HALF_CYC - 1);

  typedef enum logic [3:0] {
    ST_IDLE, ST_CLO, ST_CHI, ST_WLO, ST_WHI, ST_RLO, ST_RHI, ST_FIN, ST_GAP
  } st_t;

  st_t st;
  logic [DW-1:0] div_cnt;
  logic [2:0] bit_cnt;
  logic [7:0] tx_sh, wbuf, rx_sh;
  logic       is_rd, gap_half;

  wire tick   = (div_cnt == DLAST);
  wire accept = req_valid && req_ready;
  wire [7:0] cmd = {1'b1, req_index, req_read};
  wire last   = (bit_cnt == 3'd7);

  assign busy      = (st != ST_IDLE);
  assign req_ready = !busy;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) div_cnt <= '0;
    else if (accept || tick || !busy) div_cnt <= '0;
    else div_cnt <= div_cnt + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= ST_IDLE;
      bit_cnt <= '0;
      tx_sh <= '0;
      wbuf <= '0;
      rx_sh <= '0;
      is_rd <= 1'b0;
      gap_half <= 1'b0;
      ser_ce <= 1'b0;
      ser_clk <= 1'b0;
      ser_dout <= 1'b0;
      ser_doe <= 1'b0;
      done <= 1'b0;
      rd_byte <= '0;
    end else begin
      done <= 1'b0;
      if (st == ST_IDLE) begin
        if (accept) begin
          st <= ST_CLO;
          tx_sh <= cmd;
          ser_dout <= cmd[0];
          ser_doe <= 1'b1;
          ser_ce <= 1'b1;
          is_rd <= req_read;
          wbuf <= req_wbyte;
          bit_cnt <= '0;
        end
      end else if (tick) begin
        case (st)
          ST_CLO, ST_WLO: begin
            ser_clk <= 1'b1;
            st <= (st == ST_CLO) ? ST_CHI : ST_WHI;
          end
          ST_CHI: begin
            ser_clk <= 1'b0;
            if (last) begin
              bit_cnt <= '0;
              if (is_rd) begin
                ser_doe <= 1'b0;
                st <= ST_RLO;
              end else begin
                tx_sh <= wbuf;
                ser_dout <= wbuf[0];
                st <= ST_WLO;
              end
            end else begin
              bit_cnt <= bit_cnt + 1'b1;
              tx_sh <= tx_sh >> 1;
              ser_dout <= tx_sh[1];
              st <= ST_CLO;
            end
          end
          ST_WHI: begin
            ser_clk <= 1'b0;
            if (last) st <= ST_FIN;
            else begin
              bit_cnt <= bit_cnt + 1'b1;
              tx_sh <= tx_sh >> 1;
              ser_dout <= tx_sh[1];
              st <= ST_WLO;
            end
          end
          ST_RLO: begin
            rx_sh <= {ser_din, rx_sh[7:1]};
            if (last) st <= ST_FIN;
            else begin
              ser_clk <= 1'b1;
              st <= ST_RHI;
            end
          end
          ST_RHI: begin
            ser_clk <= 1'b0;
            bit_cnt <= bit_cnt + 1'b1;
            st <= ST_RLO;
          end
          ST_FIN: begin
            ser_ce <= 1'b0;
            ser_doe <= 1'b0;
            done <= 1'b1;
            if (is_rd) rd_byte <= rx_sh;
            gap_half <= 1'b0;
            st <= ST_GAP;
          end
          ST_GAP: begin
            if (gap_half) st <= ST_IDLE;
            else gap_half <= 1'b1;
          end
          default: st <= ST_IDLE;
        endcase
      end
    end
  end

endmodule

// File: rtl/rtc3w_master_chk.sv
module rtc3w_master_chk #(
  parameter int HALF_CYC = 4
) (
  input logic clk,
  input logic rst_n,
  input logic req_valid,
  input logic req_ready,
  input logic busy,
  input logic done,
  input logic ser_ce,
  input logic ser_clk,
  input logic ser_dout,
  input logic ser_doe
);

  logic [15:0] hi_cnt, gap_cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hi_cnt <= '0;
      gap_cnt <= '1;
    end else begin
      hi_cnt <= ser_clk ? hi_cnt + 1'b1 : '0;
      if (ser_ce) gap_cnt <= '0;
      else if (gap_cnt != 16'hFFFF) gap_cnt <= gap_cnt + 1'b1;
    end
  end

  assert_clk_low_idle_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !ser_ce |-> !ser_clk);
  assert_ce_rise_clk_low_R1: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ser_ce) |-> !ser_clk);
  assert_dout_stable_high_R2: assert property (@(posedge clk) disable iff (!rst_n)
    ser_clk |-> $stable(ser_dout));
  assert_high_width_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(ser_clk) |-> hi_cnt == 16'(HALF_CYC));
  assert_release_on_low_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(ser_doe) |-> !ser_clk);
  assert_drive_only_at_start_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ser_doe) |-> $rose(ser_ce));
  assert_done_at_ce_fall_R7: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> $fell(ser_ce) && !ser_clk);
  assert_recovery_gap_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ser_ce) |-> gap_cnt >= 16'(2 * HALF_CYC));
  assert_busy_from_accept_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(req_valid && req_ready));

endmodule

bind rtc3w_master rtc3w_master_chk #(.HALF_CYC(HALF_CYC)) u_chk (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
  .busy(busy), .done(done), .ser_ce(ser_ce), .ser_clk(ser_clk),
  .ser_dout(ser_dout), .ser_doe(ser_doe)
);

// File: tb/test_rtc3w_master.sv
module test_rtc3w_master;
  localparam int HC = 4;

  logic clk = 1'b0, rst_n = 1'b0;
  logic req_valid = 1'b0, req_read = 1'b0;
  logic [5:0] req_index = '0;
  logic [7:0] req_wbyte = '0;
  logic req_ready, busy, done, ser_ce, ser_clk, ser_dout, ser_doe;
  logic ser_din = 1'b0;
  logic [7:0] rd_byte;

  always #2.5 clk = ~clk;

  rtc3w_master #(.HALF_CYC(HC)) i_rtc3w_master (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_read(req_read), .req_index(req_index), .req_wbyte(req_wbyte),
    .busy(busy), .done(done), .rd_byte(rd_byte), .ser_ce(ser_ce),
    .ser_clk(ser_clk), .ser_dout(ser_dout), .ser_doe(ser_doe), .ser_din(ser_din)
  );

  int checks = 0, fails = 0;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  // device model
  logic [7:0] dev_mem [64];
  logic [7:0] exp_mem [64];
  logic [7:0] cmd_sh = '0, dat_sh = '0;
  int edges = 0;
  logic dev_drv = 1'b0;

  always @(posedge ser_ce) begin
    edges = 0;
    dev_drv = 1'b0;
  end
  always @(negedge ser_ce) dev_drv = 1'b0;

  always @(posedge ser_clk) if (ser_ce) begin
    if (edges < 8) cmd_sh = {ser_dout, cmd_sh[7:1]};
    else dat_sh = {ser_dout, dat_sh[7:1]};
    edges++;
  end

  always @(negedge ser_clk) if (ser_ce && cmd_sh[0] && edges >= 8 && edges <= 15) begin
    dev_drv = 1'b1;
    ser_din = dev_mem[cmd_sh[6:1]][edges-8];
  end

  // scoreboard
  typedef struct packed { logic rd; logic [5:0] idx; logic [7:0] wb; logic [7:0] exp; } item_t;
  item_t q[$];

  always @(negedge clk) if (rst_n && done) begin
    if (q.size() == 0) chk(1'b0, "R9 unexpected frame", int'(cmd_sh), 0);
    else begin
      item_t it;
      it = q.pop_front();
      chk(cmd_sh == {1'b1, it.idx, it.rd}, "R2 command byte", int'(cmd_sh), int'({1'b1, it.idx, it.rd}));
      chk(!ser_ce && !ser_clk, "R7 end framing", int'({ser_ce, ser_clk}), 0);
      if (it.rd) begin
        chk(edges == 15, "R6 read edge count", edges, 15);
        chk(rd_byte == it.exp, "R6 read byte", int'(rd_byte), int'(it.exp));
      end else begin
        chk(edges == 16, "R4 write edge count", edges, 16);
        chk(dat_sh == it.wb, "R4 write byte", int'(dat_sh), int'(it.wb));
        dev_mem[it.idx] = dat_sh;
      end
    end
  end

  // wire-level monitors
  int hi = 0, gap = 1000;
  always @(negedge clk) if (rst_n) begin
    if (!ser_ce && ser_clk) chk(1'b0, "R1 clock high without enable", 1, 0);
    if (dev_drv && ser_doe) chk(1'b0, "R5 contention", 1, 0);
    if (ser_clk) hi++;
    else if (hi != 0) begin
      chk(hi == HC, "R3 high width", hi, HC);
      hi = 0;
    end
    if (ser_ce) begin
      if (gap != 0) chk(gap >= 2 * HC, "R8 recovery gap", gap, 2 * HC);
      gap = 0;
    end else gap++;
  end

  task automatic send(input bit rd, input logic [5:0] idx, input logic [7:0] wb);
    item_t it;
    @(negedge clk);
    while (!req_ready) @(negedge clk);
    req_valid = 1'b1; req_read = rd; req_index = idx; req_wbyte = wb;
    @(negedge clk);
    req_valid = 1'b0;
    chk(busy && !req_ready, "R9 busy after accept", int'({busy, req_ready}), 2);
    it.rd = rd; it.idx = idx; it.wb = wb; it.exp = exp_mem[idx];
    if (!rd) exp_mem[idx] = wb;
    q.push_back(it);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    for (int i = 0; i < 64; i++) begin
      dev_mem[i] = 8'(i * 37 + 5);
      exp_mem[i] = 8'(i * 37 + 5);
    end
    repeat (3) @(negedge clk);
    chk(!ser_ce && !ser_clk && !ser_doe && !done, "R10 reset outputs", int'({ser_ce, ser_clk, ser_doe, done}), 0);
    chk(req_ready && !busy, "R10 ready in reset", int'({req_ready, busy}), 2);
    rst_n = 1'b1;
    @(negedge clk);
    chk(req_ready && !ser_ce, "R10 ready after reset", int'({req_ready, ser_ce}), 2);

    send(1'b1, 6'd0, 8'h00);
    send(1'b0, 6'd0, 8'hA5);
    send(1'b1, 6'd0, 8'h00);
    send(1'b0, 6'd63, 8'hFF);
    send(1'b1, 6'd63, 8'h00);
    send(1'b0, 6'd7, 8'h00);
    send(1'b1, 6'd7, 8'h00);
    send(1'b0, 6'd21, 8'h5A);
    // request while busy must be ignored (R9)
    repeat (10) @(negedge clk);
    req_valid = 1'b1; req_read = 1'b0; req_index = 6'd21; req_wbyte = 8'h33;
    repeat (3) @(negedge clk);
    chk(busy, "R9 still busy during ignored request", int'(busy), 1);
    req_valid = 1'b0;
    send(1'b1, 6'd21, 8'h00);
    send(1'b1, 6'd42, 8'h00);
    send(1'b0, 6'd1, 8'h81);
    send(1'b1, 6'd1, 8'h00);

    while (q.size() != 0 || busy) @(negedge clk);
    repeat (4 * HC) @(negedge clk);
    chk(!ser_ce && !ser_clk && !ser_doe, "R1 idle after all frames", int'({ser_ce, ser_clk, ser_doe}), 0);
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule